// File: doc/BRIEF.md
# Protected-Page Bank Register Trap

This block handles stores that fault because they land on the write-protected top page of the main data segment. It takes a trap request that carries the faulting virtual address (low and high halves) and the store data, and decides what to do with it. A store to the emulator task's bank-select word loads that task's 2-bit alternate bank. A store to the display task's bank-select word loads the display's 2-bit normal bank and recomputes the display base-high value from the emulator's current base-high.

Any store into the small bank-register area at the top of the page is then committed to memory under a temporary unprotect. The block flushes the cache line, opens write protection in the map, performs the store, flushes the line again and closes protection. A store to any other word of the page is dropped. A store outside the page is reported as a map fault. The map, the cache and the memory are reached through simple request/acknowledge ports. One completion pulse, with a status code, lets the requester resume at the following instruction.

Top module: `bankreg_trap`

## Requirements
- R1: A trap is in the page when `(trap_va_lo & 16'o177400) == 16'o177400` and `trap_va_hi[11:0] == emu_base_hi`. The upper four bits of `trap_va_hi` are ignored. A trap outside the page completes with status 3 (map fault), issues no map, cache or memory request and changes no bank register.
- R2: A trap in the page whose low address does not satisfy `(trap_va_lo & 16'o177740) == 16'o177740` completes with status 2 (ignored). It issues no request and changes no bank register.
- R3: A trap in the page to low address 16'o177740 sets `alt_bank` to `trap_data[1:0]` and completes with status 1 (register updated) after the commit sequence.
- R4: A trap in the page to low address 16'o177751 sets `disp_bank` to `trap_data[3:2]` and sets `disp_base_hi` to `(emu_base_hi + trap_data[3:2]) mod 4096`. It completes with status 1 after the commit sequence.
- R5: A trap to any other word of the bank-register area runs the full commit sequence, completes with status 0 (committed) and leaves all bank registers unchanged.
- R6: The commit sequence runs in a fixed order. First a cache flush, then a map write with `map_wprot`=0, then a memory store of `trap_data`, then a second cache flush, then a map write with `map_wprot`=1. Every step carries the faulting low address and holds its request high until the matching acknowledge is sampled.
- R7: At most one of `cache_req`, `map_req` and `mem_req` is high in any cycle. The next step's request rises in the cycle after the previous step's acknowledge.
- R8: `busy` rises in the cycle after a trap is accepted and stays high through the completion cycle. `done` is high for exactly one cycle, the last cycle of `busy`, and `status` is valid while `done` is high.
- R9: `trap_valid` is ignored while `busy` is high.
- R10: After synchronous reset `alt_bank`, `disp_bank` and `disp_base_hi` are zero, and `busy`, `done` and all requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap request (accepted when not busy) |
| trap_va_lo | input | 16 | Low half of the faulting virtual address |
| trap_va_hi | input | 16 | High half of the faulting virtual address |
| trap_data | input | 16 | Data of the faulting store |
| emu_base_hi | input | 12 | Emulator's current base-high value |
| busy | output | 1 | Trap in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 committed, 1 register updated, 2 ignored, 3 map fault |
| alt_bank | output | 2 | Emulator task alternate bank |
| disp_bank | output | 2 | Display task normal bank |
| disp_base_hi | output | 12 | Display base-high value |
| cache_req | output | 1 | Cache line flush request |
| cache_addr | output | 16 | Address to flush |
| cache_ack | input | 1 | Flush complete |
| map_req | output | 1 | Map entry write request |
| map_addr | output | 16 | Address whose map entry is written |
| map_wprot | output | 1 | Write-protect value for the map write |
| map_ack | input | 1 | Map write complete |
| mem_req | output | 1 | Memory store request |
| mem_addr | output | 16 | Store address |
| mem_data | output | 16 | Store data |
| mem_ack | input | 1 | Store complete |

## Verification
The bench drives stores to both bank-select words, to another word inside the register area, to a word elsewhere in the page, and to addresses outside the page through each of the two match conditions. These cases separate the four completion codes and show which stores touch memory. A display-bank store with base-high 12'hFFF shows that the derived base wraps. The commit sequence is run with zero-cycle and multi-cycle acknowledge latency to confirm ordering and request holding. A second trap is presented while one is in flight to show that it is not taken.

// File: rtl/bankreg_trap_pkg.sv
package bankreg_trap_pkg;

    localparam logic [15:0] PAGE_MASK    = 16'o177400;
    localparam logic [15:0] AREA_MASK    = 16'o177740;
    localparam logic [15:0] EMU_BANK_VA  = 16'o177740;
    localparam logic [15:0] DISP_BANK_VA = 16'o177751;

    typedef enum logic [1:0] {
        TS_COMMITTED = 2'd0,
        TS_UPDATED   = 2'd1,
        TS_IGNORED   = 2'd2,
        TS_MAPFAULT  = 2'd3
    } trap_status_e;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_FLUSH_A = 3'd1,
        SQ_OPEN    = 3'd2,
        SQ_STORE   = 3'd3,
        SQ_FLUSH_B = 3'd4,
        SQ_CLOSE   = 3'd5,
        SQ_FIN     = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic         commit;
        logic         set_alt;
        logic         set_disp;
        trap_status_e status;
    } trap_class_t;

    function automatic trap_class_t classify(input logic [15:0] lo,
                                             input logic       hi_match);
        trap_class_t c;
        c = '{commit: 1'b0, set_alt: 1'b0, set_disp: 1'b0, status: TS_MAPFAULT};
        if (hi_match && ((lo & PAGE_MASK) == PAGE_MASK)) begin
            if ((lo & AREA_MASK) != AREA_MASK) begin
                c.status = TS_IGNORED;
            end else begin
                c.commit   = 1'b1;
                c.set_alt  = (lo == EMU_BANK_VA);
                c.set_disp = (lo == DISP_BANK_VA);
                c.status   = (c.set_alt || c.set_disp) ? TS_UPDATED : TS_COMMITTED;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/trap_decode.sv
module trap_decode
    import bankreg_trap_pkg::*;
#(
    parameter int BASE_W = 12
) (
    input  logic [15:0]       va_lo,
    input  logic [15:0]       va_hi,
    input  logic [BASE_W-1:0] emu_base_hi,
    output trap_class_t       cls
);
    localparam logic [15:0] HI_MASK = 16'((32'd1 << BASE_W) - 1);

    logic hi_match;

    always_comb begin
        hi_match = ((va_hi & HI_MASK) == {{(16-BASE_W){1'b0}}, emu_base_hi});
        cls      = classify(va_lo, hi_match);
    end

endmodule

// File: rtl/bank_regs.sv
module bank_regs #(
    parameter int BASE_W = 12,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_alt,
    input  logic              set_disp,
    input  logic [BANK_W-1:0] alt_fld,
    input  logic [BANK_W-1:0] disp_fld,
    input  logic [BASE_W-1:0] emu_base_hi,
    output logic [BANK_W-1:0] alt_bank,
    output logic [BANK_W-1:0] disp_bank,
    output logic [BASE_W-1:0] disp_base_hi
);
    localparam int PAD_W = BASE_W - BANK_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            alt_bank     <= '0;
            disp_bank    <= '0;
            disp_base_hi <= '0;
        end else begin
            if (set_alt) begin
                alt_bank <= alt_fld;
            end
            if (set_disp) begin
                disp_bank    <= disp_fld;
                disp_base_hi <= emu_base_hi + {{PAD_W{1'b0}}, disp_fld};
            end
        end
    end

    AST_DISP_BASE_SUM: assert property (@(posedge clk) disable iff (rst)
        set_disp |=> disp_base_hi == $past(emu_base_hi) + {{PAD_W{1'b0}}, $past(disp_fld)}); // R4

endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import bankreg_trap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_commit,
    input  trap_status_e      start_status,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              cache_req,
    output logic [ADDR_W-1:0] cache_addr,
    input  logic              cache_ack,
    output logic              map_req,
    output logic [ADDR_W-1:0] map_addr,
    output logic              map_wprot,
    input  logic              map_ack,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_ack
);
    seq_state_e        state_q, state_d;
    trap_status_e      status_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:    if (start) state_d = start_commit ? SQ_FLUSH_A : SQ_FIN;
            SQ_FLUSH_A: if (cache_ack) state_d = SQ_OPEN;
            SQ_OPEN:    if (map_ack) state_d = SQ_STORE;
            SQ_STORE:   if (mem_ack) state_d = SQ_FLUSH_B;
            SQ_FLUSH_B: if (cache_ack) state_d = SQ_CLOSE;
            SQ_CLOSE:   if (map_ack) state_d = SQ_FIN;
            SQ_FIN:     state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            status_q <= TS_COMMITTED;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_IDLE && start) begin
                status_q <= start_status;
                addr_q   <= start_addr;
                data_q   <= start_data;
            end
        end
    end

    always_comb begin
        busy       = (state_q != SQ_IDLE);
        done       = (state_q == SQ_FIN);
        status     = status_q;
        cache_req  = (state_q == SQ_FLUSH_A) || (state_q == SQ_FLUSH_B);
        map_req    = (state_q == SQ_OPEN) || (state_q == SQ_CLOSE);
        map_wprot  = (state_q == SQ_CLOSE);
        mem_req    = (state_q == SQ_STORE);
        cache_addr = addr_q;
        map_addr   = addr_q;
        mem_addr   = addr_q;
        mem_data   = data_q;
    end

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cache_req, map_req, mem_req})); // R7

    AST_STORE_AFTER_OPEN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(map_req && map_ack && !map_wprot)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done)); // R8

endmodule

// File: rtl/bankreg_trap.sv
module bankreg_trap
    import bankreg_trap_pkg::*;
#(
    parameter int BASE_W = 12,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_valid,
    input  logic [15:0]       trap_va_lo,
    input  logic [15:0]       trap_va_hi,
    input  logic [15:0]       trap_data,
    input  logic [BASE_W-1:0] emu_base_hi,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [BANK_W-1:0] alt_bank,
    output logic [BANK_W-1:0] disp_bank,
    output logic [BASE_W-1:0] disp_base_hi,
    output logic              cache_req,
    output logic [15:0]       cache_addr,
    input  logic              cache_ack,
    output logic              map_req,
    output logic [15:0]       map_addr,
    output logic              map_wprot,
    input  logic              map_ack,
    output logic              mem_req,
    output logic [15:0]       mem_addr,
    output logic [15:0]       mem_data,
    input  logic              mem_ack
);
    trap_class_t cls;
    logic        accept;

    assign accept = trap_valid && !busy;

    trap_decode #(.BASE_W(BASE_W)) decode_i (
        .va_lo       (trap_va_lo),
        .va_hi       (trap_va_hi),
        .emu_base_hi (emu_base_hi),
        .cls         (cls)
    );

    bank_regs #(.BASE_W(BASE_W), .BANK_W(BANK_W)) regs_i (
        .clk          (clk),
        .rst          (rst),
        .set_alt      (accept && cls.set_alt),
        .set_disp     (accept && cls.set_disp),
        .alt_fld      (trap_data[BANK_W-1:0]),
        .disp_fld     (trap_data[2*BANK_W-1:BANK_W]),
        .emu_base_hi  (emu_base_hi),
        .alt_bank     (alt_bank),
        .disp_bank    (disp_bank),
        .disp_base_hi (disp_base_hi)
    );

    trap_seq #(.ADDR_W(16), .DATA_W(16)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .start        (accept),
        .start_commit (cls.commit),
        .start_status (cls.status),
        .start_addr   (trap_va_lo),
        .start_data   (trap_data),
        .busy         (busy),
        .done         (done),
        .status       (status),
        .cache_req    (cache_req),
        .cache_addr   (cache_addr),
        .cache_ack    (cache_ack),
        .map_req      (map_req),
        .map_addr     (map_addr),
        .map_wprot    (map_wprot),
        .map_ack      (map_ack),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_data     (mem_data),
        .mem_ack      (mem_ack)
    );

    AST_REGS_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(alt_bank) && $stable(disp_bank) && $stable(disp_base_hi)); // R9

    AST_NO_REQ_WHEN_REJECTED: assert property (@(posedge clk) disable iff (rst)
        (accept && !cls.commit) |=> !cache_req && !map_req && !mem_req && done); // R1

endmodule

// File: tb/bankreg_trap_tb_top.sv
module bankreg_trap_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_valid = 1'b0;
    logic [15:0] trap_va_lo = '0, trap_va_hi = '0, trap_data = '0;
    logic [11:0] ebh = '0;
    logic        busy, done;
    logic [1:0]  status, alt_bank, disp_bank;
    logic [11:0] disp_base_hi;
    logic        cache_req, map_req, map_wprot, mem_req;
    logic [15:0] cache_addr, map_addr, mem_addr, mem_data;
    logic        cache_ack = 1'b0, map_ack = 1'b0, mem_ack = 1'b0;

    int n_chk = 0, n_fail = 0, dly = 0;
    int c_cnt = 0, m_cnt = 0, s_cnt = 0;

    always #5 clk = ~clk;

    bankreg_trap dut_i (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_va_lo(trap_va_lo),
        .trap_va_hi(trap_va_hi), .trap_data(trap_data), .emu_base_hi(ebh),
        .busy(busy), .done(done), .status(status), .alt_bank(alt_bank),
        .disp_bank(disp_bank), .disp_base_hi(disp_base_hi),
        .cache_req(cache_req), .cache_addr(cache_addr), .cache_ack(cache_ack),
        .map_req(map_req), .map_addr(map_addr), .map_wprot(map_wprot), .map_ack(map_ack),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: phase 0 idle, 1..5 commit steps, 6 completion
    int          ph = 0;
    logic [1:0]  e_alt = '0, e_disp = '0, e_st = '0;
    logic [11:0] e_dbh = '0;
    logic [15:0] e_addr = '0, e_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; e_alt = '0; e_disp = '0; e_dbh = '0; e_st = '0;
        end else begin
            case (ph)
                0: if (trap_valid) begin
                    e_addr = trap_va_lo;
                    e_data = trap_data;
                    if (!((trap_va_lo[15:8] == 8'hFF) && (trap_va_hi[11:0] == ebh))) begin
                        e_st = 2'd3; ph = 6;
                    end else if (trap_va_lo[7:5] != 3'b111) begin
                        e_st = 2'd2; ph = 6;
                    end else begin
                        ph = 1;
                        if (trap_va_lo == 16'hFFE0) begin
                            e_alt = trap_data[1:0]; e_st = 2'd1;
                        end else if (trap_va_lo == 16'hFFE9) begin
                            e_disp = trap_data[3:2];
                            e_dbh = 12'((int'(ebh) + int'(trap_data[3:2])) % 4096);
                            e_st = 2'd1;
                        end else begin
                            e_st = 2'd0;
                        end
                    end
                end
                1: if (cache_ack) ph = 2;
                2: if (map_ack) ph = 3;
                3: if (mem_ack) ph = 4;
                4: if (cache_ack) ph = 5;
                5: if (map_ack) ph = 6;
                default: ph = 0;
            endcase
        end
    end

    // Acknowledge responders with programmable latency
    always @(negedge clk) begin
        if (cache_req && !cache_ack) begin
            if (c_cnt >= dly) begin cache_ack <= 1'b1; c_cnt <= 0; end else c_cnt <= c_cnt + 1;
        end else cache_ack <= 1'b0;
        if (map_req && !map_ack) begin
            if (m_cnt >= dly) begin map_ack <= 1'b1; m_cnt <= 0; end else m_cnt <= m_cnt + 1;
        end else map_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (s_cnt >= dly) begin mem_ack <= 1'b1; s_cnt <= 0; end else s_cnt <= s_cnt + 1;
        end else mem_ack <= 1'b0;
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            chk("R8 busy", 32'(busy), 32'(ph != 0));
            chk("R8 done", 32'(done), 32'(ph == 6));
            chk("R6 cache_req", 32'(cache_req), 32'(ph == 1 || ph == 4));
            chk("R6 map_req", 32'(map_req), 32'(ph == 2 || ph == 5));
            chk("R6 mem_req", 32'(mem_req), 32'(ph == 3));
            chk("R7 one request", 32'($countones({cache_req, map_req, mem_req}) <= 1), 32'd1);
            chk("R3 alt_bank", 32'(alt_bank), 32'(e_alt));
            chk("R4 disp_bank", 32'(disp_bank), 32'(e_disp));
            chk("R4 disp_base_hi", 32'(disp_base_hi), 32'(e_dbh));
            if (cache_req) chk("R6 cache_addr", 32'(cache_addr), 32'(e_addr));
            if (map_req) begin
                chk("R6 map_addr", 32'(map_addr), 32'(e_addr));
                chk("R6 map_wprot", 32'(map_wprot), 32'(ph == 5));
            end
            if (mem_req) begin
                chk("R6 mem_addr", 32'(mem_addr), 32'(e_addr));
                chk("R6 mem_data", 32'(mem_data), 32'(e_data));
            end
            if (done) begin
                case (e_st)
                    2'd3: chk("R1 status", 32'(status), 32'd3);
                    2'd2: chk("R2 status", 32'(status), 32'd2);
                    2'd1: chk("R3 R4 status", 32'(status), 32'd1);
                    default: chk("R5 status", 32'(status), 32'd0);
                endcase
            end
        end
    end

    task automatic trap(input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] d);
        @(negedge clk);
        trap_valid = 1'b1; trap_va_lo = lo; trap_va_hi = hi; trap_data = d;
        @(negedge clk);
        trap_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", 32'(busy), 32'd0);
        chk("R10 alt_bank", 32'(alt_bank), 32'd0);
        chk("R10 disp_base_hi", 32'(disp_base_hi), 32'd0);
        chk("R10 requests", 32'({cache_req, map_req, mem_req, done}), 32'd0);

        ebh = 12'h123;
        dly = 0;
        trap(16'o177740, 16'h0123, 16'hABCF);          // R3 alt = 3
        trap(16'o177751, 16'hF123, 16'h0008);          // R4 disp = 2, upper hi bits ignored (R1)
        dly = 3;
        trap(16'o177740, 16'h0123, 16'h0002);          // R3 alt = 2, slow acks
        ebh = 12'hFFF;
        trap(16'o177751, 16'h0FFF, 16'h000C);          // R4 wrap: FFF + 3
        trap(16'o177745, 16'h0FFF, 16'h5555);          // R5 committed, no change
        dly = 0;
        trap(16'o177777, 16'h0FFF, 16'h0001);          // R5 top word of area
        trap(16'o177400, 16'h0FFF, 16'h0003);          // R2 ignored
        trap(16'o177737, 16'h0FFF, 16'h0003);          // R2 just below area
        trap(16'o177740, 16'h0FFE, 16'h0001);          // R1 hi mismatch -> map fault
        trap(16'o077740, 16'h0FFF, 16'h0001);          // R1 lo outside page
        chk("R1 alt unchanged by fault", 32'(alt_bank), 32'd2);

        // R9: second trap offered while busy
        dly = 2;
        @(negedge clk);
        trap_valid = 1'b1; trap_va_lo = 16'o177745; trap_va_hi = 16'h0FFF; trap_data = 16'h0;
        @(negedge clk);
        trap_va_lo = 16'o177740; trap_data = 16'h0001;
        repeat (4) @(negedge clk);
        trap_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R9 alt unchanged", 32'(alt_bank), 32'd2);
        chk("R9 idle after", 32'(busy), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule